// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller turns single-bit host reads and writes into strobe sequences for a DRAM whose row and column addresses share one set of address pins. A 12-bit host address is split: the upper six bits go out first as the row and are latched by a falling row strobe. The lower six bits follow as the column and are latched by a falling column strobe. All strobes are active low. Writes replace the addressed bit while the column strobe is low, and the modified row is written back when the row strobe rises. Reads capture the device output at the end of the column phase.

A free-running interval counter marks a refresh as due. The refresh is started before any new host request, but a cycle already in progress always runs to its end. Each refresh is one of two kinds, chosen per refresh by a mode input. In row-strobe-only refresh, the controller drives its own 6-bit row pointer and then advances it. In column-before-row refresh, the device counts rows itself and the address pins stay at zero. Phase lengths and the refresh interval are parameters counted in clock cycles.

Top module: `dramc_top`

## Requirements
- R1: While rst_ni is low, all three strobes are high, dram_addr_o is 0, rdata_o is 0 and ready_o is 1.
- R2: ready_o is 1 exactly when the controller is idle and no refresh is due. A request is taken only in a cycle with req_i and ready_o both high. A req_i raised while ready_o is low has no effect on the array.
- R3: On the falling row strobe of a host cycle, dram_addr_o equals addr_i[11:6]. On the falling column strobe, it equals addr_i[5:0].
- R4: The row strobe is low for at least T_RCD cycles before the column strobe falls. The column strobe stays low for at least T_CAS cycles. The row strobe stays high for at least T_RP cycles between two falls.
- R5: In a write, dram_we_no is already low in the cycle before the column strobe falls, and dram_din_o carries wdata_i. The row strobe then rises while the column strobe and dram_we_no are still low. The column strobe rises in a later cycle.
- R6: A read returns in rdata_o the device output from the last cycle of the column phase. The value is valid once ready_o returns, and it is held unchanged through later writes.
- R7: A refresh becomes due once every REF_CYCLES = CLK_MHZ*REF_PERIOD_NS/1000 cycles. A due refresh is started before a waiting host request and never cuts a running cycle short.
- R8: With refresh_mode_i = 0, a refresh drives the internal row pointer on dram_addr_o and pulses the row strobe while the column strobe stays high. The pointer starts at 0 after reset and steps by one modulo 64 after each such refresh.
- R9: With refresh_mode_i = 1, the column strobe falls at least one cycle before the row strobe, dram_addr_o is 0 and dram_we_no is high. The internal row pointer does not move.
- R10: A read of any address returns the last bit written to it.
- R11: Under row-strobe-only refresh, every one of the 64 rows receives a refresh within 64 refresh intervals plus the time taken by host cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 12 | Host address: row in [11:6], column in [5:0] |
| wdata_i | input | 1 | Host write bit |
| refresh_mode_i | input | 1 | 0: controller row pointer; 1: column strobe before row strobe |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 1 | Last read bit |
| dram_addr_o | output | 6 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_din_o | output | 1 | Data to device |
| dram_dout_i | input | 1 | Data from device |

## Verification
A refresh falling due and a host request can arrive in the same cycle. This happens throughout a long run of random back-to-back host traffic, because the interval counter runs independently of the traffic. Each such collision is judged three ways. The refresh count over the run must match the elapsed intervals within one. Every row-strobe-only refresh must carry the next pointer value. Every read must return the shadow-memory value, which shows that no host cycle was cut or reordered by a refresh.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_WBACK,
    ST_PRECH,
    ST_RREF,
    ST_CBR_C,
    ST_CBR_R
  } dramc_state_e;
endpackage

// File: rtl/dramc_phase_cnt.sv
module dramc_phase_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dramc_ref_sched.sv
module dramc_ref_sched #(
  parameter int INTERVAL = 7812,
  parameter int ROW_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0]    cnt_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             tick;

  assign tick = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      pend_q <= tick | (pend_q & ~start_i);
      if (step_i) row_q <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q != $past(row_q) |-> row_q == $past(row_q) + ROW_W'(1)); // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !start_i |=> pend_q); // R7
endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
  import dramc_pkg::*;
#(
  parameter int ROW_W     = 6,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_REF = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   wdata_i,
  input  logic                   mode_i,
  input  logic                   ref_pend_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic                   ready_o,
  output logic                   rdata_o,
  output logic                   ref_start_o,
  output logic                   ref_step_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic                   dram_din_o,
  input  logic                   dram_dout_i
);
  localparam int AW    = ROW_W + COL_W;
  localparam int MW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_CBR = (T_RAS_REF > T_CAS) ? T_RAS_REF : T_CAS;
  localparam int TM1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2   = (T_RP > T_CBR) ? T_RP : T_CBR;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW    = $clog2(TMAX + 1);

  dramc_state_e state_q, state_d;
  logic          op_we_q, op_wd_q, rdata_q;
  logic [AW-1:0] op_addr_q;
  logic          ph_zero, accept;

  function automatic logic [CW-1:0] hold_len(dramc_state_e s);
    case (s)
      ST_ROW:   return CW'(T_RCD - 1);
      ST_COL:   return CW'(T_CAS - 1);
      ST_PRECH: return CW'(T_RP - 1);
      ST_RREF:  return CW'(T_RAS_REF - 1);
      ST_CBR_R: return CW'(T_CBR - 1);
      default:  return '0;
    endcase
  endfunction

  assign ready_o     = (state_q == ST_IDLE) && !ref_pend_i;
  assign accept      = ready_o && req_i;
  assign ref_start_o = (state_q == ST_IDLE) && ref_pend_i;
  assign ref_step_o  = (state_q == ST_RREF) && ph_zero;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ref_pend_i) state_d = mode_i ? ST_CBR_C : ST_RREF;
        else if (req_i) state_d = ST_ROW;
      end
      ST_ROW:   if (ph_zero) state_d = ST_COL;
      ST_COL:   if (ph_zero) state_d = op_we_q ? ST_WBACK : ST_PRECH;
      ST_WBACK: if (ph_zero) state_d = ST_PRECH;
      ST_PRECH: if (ph_zero) state_d = ST_IDLE;
      ST_RREF:  if (ph_zero) state_d = ST_PRECH;
      ST_CBR_C: if (ph_zero) state_d = ST_CBR_R;
      ST_CBR_R: if (ph_zero) state_d = ST_PRECH;
      default:  state_d = ST_IDLE;
    endcase
  end

  dramc_phase_cnt #(.W(CW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_d != state_q),
    .val_i  (hold_len(state_d)),
    .zero_o (ph_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_we_q   <= 1'b0;
      op_wd_q   <= 1'b0;
      op_addr_q <= '0;
      rdata_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_we_q   <= we_i;
        op_wd_q   <= wdata_i;
        op_addr_q <= addr_i;
      end
      if (state_q == ST_COL && ph_zero && !op_we_q) rdata_q <= dram_dout_i;
    end
  end

  assign rdata_o = rdata_q;

  // strobes decoded from state; each phase is held by the phase counter
  always_comb begin
    dram_ras_no = !(state_q inside {ST_ROW, ST_COL, ST_RREF, ST_CBR_R});
    dram_cas_no = !(state_q inside {ST_COL, ST_WBACK, ST_CBR_C, ST_CBR_R});
    dram_we_no  = !(op_we_q && (state_q inside {ST_ROW, ST_COL, ST_WBACK}));
    dram_din_o  = op_we_q && (state_q inside {ST_COL, ST_WBACK}) && op_wd_q;
    case (state_q)
      ST_ROW:          dram_addr_o = MW'(op_addr_q[AW-1:COL_W]);
      ST_COL, ST_WBACK: dram_addr_o = MW'(op_addr_q[COL_W-1:0]);
      ST_RREF:         dram_addr_o = MW'(ref_row_i);
      default:         dram_addr_o = '0;
    endcase
  end

  // run-length monitors for the timing assertions
  localparam int RW = $clog2(TMAX + 2) + 1;
  logic [RW-1:0] ras_lo_run, ras_hi_run, cas_lo_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_lo_run <= '0;
      ras_hi_run <= RW'(TMAX + 1);
      cas_lo_run <= '0;
    end else begin
      ras_lo_run <= dram_ras_no ? '0 : (ras_lo_run > RW'(TMAX) ? ras_lo_run : ras_lo_run + 1'b1);
      ras_hi_run <= !dram_ras_no ? '0 : (ras_hi_run > RW'(TMAX) ? ras_hi_run : ras_hi_run + 1'b1);
      cas_lo_run <= dram_cas_no ? '0 : (cas_lo_run > RW'(TMAX) ? cas_lo_run : cas_lo_run + 1'b1);
    end
  end

  AST_RCD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_ras_no |-> ras_lo_run >= RW'(T_RCD)); // R4
  AST_CAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> cas_lo_run >= RW'(T_CAS)); // R4
  AST_RP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> ras_hi_run >= RW'(T_RP)); // R4
  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_we_no |-> $past(!dram_we_no)); // R5
  AST_WB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) && $past(!dram_we_no) |-> !dram_cas_no && !dram_we_no); // R5
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) && !dram_cas_no |-> $past(!dram_cas_no) && dram_addr_o == '0 && dram_we_no); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> dram_ras_no && dram_cas_no); // R2
  AST_REF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend_i && state_q == ST_IDLE |=> state_q == ST_RREF || state_q == ST_CBR_C); // R7
endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int ROW_W         = 6,
  parameter int COL_W         = 6,
  parameter int CLK_MHZ       = 125,
  parameter int REF_PERIOD_NS = 62500,
  parameter int T_RCD         = 2,
  parameter int T_CAS         = 2,
  parameter int T_RP          = 2,
  parameter int T_RAS_REF     = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   wdata_i,
  input  logic                   refresh_mode_i,
  output logic                   ready_o,
  output logic                   rdata_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic                   dram_din_o,
  input  logic                   dram_dout_i
);
  localparam int REF_CYCLES = (CLK_MHZ * REF_PERIOD_NS) / 1000;

  logic             ref_pend, ref_start, ref_step;
  logic [ROW_W-1:0] ref_row;

  dramc_ref_sched #(.INTERVAL(REF_CYCLES), .ROW_W(ROW_W)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ref_start),
    .step_i  (ref_step),
    .pend_o  (ref_pend),
    .row_o   (ref_row)
  );

  dramc_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RAS_REF(T_RAS_REF)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mode_i      (refresh_mode_i),
    .ref_pend_i  (ref_pend),
    .ref_row_i   (ref_row),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .ref_start_o (ref_start),
    .ref_step_o  (ref_step),
    .dram_addr_o (dram_addr_o),
    .dram_ras_no (dram_ras_no),
    .dram_cas_no (dram_cas_no),
    .dram_we_no  (dram_we_no),
    .dram_din_o  (dram_din_o),
    .dram_dout_i (dram_dout_i)
  );
endmodule

// File: tb/dramc_top_test.sv
`timescale 1ns/1ps
module dramc_top_test;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS_REF = 3;
  localparam int CLK_MHZ = 125, REF_NS = 500;
  localparam int REF = CLK_MHZ * REF_NS / 1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req = 1'b0, we = 1'b0, wdata = 1'b0, mode = 1'b0;
  logic [11:0] addr = '0;
  logic ready, rdata, ras_n, cas_n, we_n, din;
  logic [5:0] daddr;
  logic dout_r = 1'b0;

  dramc_top #(.CLK_MHZ(CLK_MHZ), .REF_PERIOD_NS(REF_NS), .T_RCD(T_RCD),
              .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_REF(T_RAS_REF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .refresh_mode_i(mode), .ready_o(ready), .rdata_o(rdata),
    .dram_addr_o(daddr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_din_o(din), .dram_dout_i(dout_r));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit init_bit(input int i);
    return bit'(((i * 7) >> 2) & 1);
  endfunction

  bit dev_mem [4096];
  bit exp_mem [4096];
  int row_ref_cnt [64];
  bit prev_ras = 1, prev_cas = 1, prev_we = 1, cas_in_ras = 0, cbr_kind = 0;
  int ras_lo_run = 0, ras_hi_run = 1000, cas_lo_run = 0;
  logic [5:0] lat_row = 0, host_row = 0, host_col = 0, exp_ptr = 0, dev_ptr = 0;
  int ro_cnt = 0, cbr_cnt = 0;
  bit last_rd = 0;

  // device model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && prev_ras) begin
        chk(ras_hi_run >= T_RP, "R4 precharge", ras_hi_run, T_RP);
        if (!cas_n) begin
          chk(!prev_cas, "R9 cas before ras", int'(prev_cas), 0);
          chk(daddr == 0, "R9 addr zero", int'(daddr), 0);
          chk(we_n == 1'b1, "R9 we high", int'(we_n), 1);
          cbr_kind = 1;
          cbr_cnt++;
          row_ref_cnt[dev_ptr]++;
          dev_ptr++;
        end else begin
          cbr_kind = 0;
          lat_row = daddr;
          cas_in_ras = 0;
        end
      end
      if (!cas_n && prev_cas && !ras_n) begin
        chk(ras_lo_run >= T_RCD, "R4 ras to cas", ras_lo_run, T_RCD);
        host_row = lat_row;
        host_col = daddr;
        cas_in_ras = 1;
        if (!we_n) begin
          chk(!prev_we, "R5 we before cas", int'(prev_we), 0);
          dev_mem[{lat_row, daddr}] = din;
        end else dout_r = dev_mem[{lat_row, daddr}];
      end
      if (cas_n && !prev_cas) begin
        chk(cas_lo_run >= T_CAS, "R4 cas width", cas_lo_run, T_CAS);
        dout_r = 1'b0;
      end
      if (ras_n && !prev_ras) begin
        if (!prev_we) begin
          chk(!cas_n && !we_n, "R5 ras rises under cas and we", int'({cas_n, we_n}), 0);
        end
        if (!cas_in_ras && !cbr_kind) begin
          chk(lat_row == exp_ptr, "R8 refresh row", int'(lat_row), int'(exp_ptr));
          row_ref_cnt[lat_row]++;
          exp_ptr++;
          ro_cnt++;
        end
      end
      ras_lo_run = !ras_n ? ras_lo_run + 1 : 0;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = !cas_n ? cas_lo_run + 1 : 0;
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
    end
  end

  task automatic host_op(input bit w, input logic [11:0] a, input bit d, input bit intrude);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    if (intrude) begin
      // R2: request while ready_o is low must be dropped
      req = 1'b1; we = 1'b1; addr = 12'h2AA; wdata = ~exp_mem[12'h2AA];
      @(negedge clk); @(negedge clk);
      req = 1'b0;
    end
    while (!ready) @(negedge clk);
    chk(host_row == a[11:6], "R3 row half", int'(host_row), int'(a[11:6]));
    chk(host_col == a[5:0], "R3 column half", int'(host_col), int'(a[5:0]));
    if (w) begin
      exp_mem[a] = d;
      chk(rdata == last_rd, "R6 rdata held over write", int'(rdata), int'(last_rd));
    end else begin
      chk(rdata == exp_mem[a], "R10 R6 read data", int'(rdata), int'(exp_mem[a]));
      last_rd = exp_mem[a];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed, c0, c1, cyc0;
    seed = $urandom(32'h5EED_0017);
    for (int i = 0; i < 4096; i++) begin
      dev_mem[i] = init_bit(i);
      exp_mem[i] = init_bit(i);
    end
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(daddr == 0, "R1 addr zero", int'(daddr), 0);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(rdata == 1'b0, "R1 rdata", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    host_op(1, 12'hFFF, 1'b1, 0);
    host_op(1, 12'h000, 1'b0, 0);
    host_op(0, 12'hFFF, 0, 0);
    host_op(0, 12'h000, 0, 0);
    host_op(1, 12'h03F, ~init_bit(12'h03F), 0);
    host_op(1, 12'hFC0, ~init_bit(12'hFC0), 0);
    host_op(0, 12'h03F, 0, 0);
    host_op(0, 12'hFC0, 0, 0);
    host_op(1, 12'h555, 1'b1, 1);
    host_op(0, 12'h2AA, 0, 0); // R2 intruding write left no trace
    host_op(0, 12'h555, 0, 0);

    // random traffic colliding with refresh
    c0 = ro_cnt + cbr_cnt;
    cyc0 = 0;
    fork
      begin : cyc_cnt
        forever begin @(posedge clk); cyc0++; end
      end
      begin
        for (int k = 0; k < 300; k++) begin
          logic [11:0] a;
          a = 12'($urandom);
          if ($urandom % 3 == 0) a = {a[11:6], 6'($urandom % 4)};
          host_op(1'($urandom), a, 1'($urandom), 0);
        end
      end
    join_any
    disable cyc_cnt;
    c1 = ro_cnt + cbr_cnt - c0;
    chk(c1 >= cyc0 / REF - 1 && c1 <= cyc0 / REF + 1, "R7 refresh rate under traffic", c1, cyc0 / REF);

    // idle, row-strobe-only refresh
    c0 = ro_cnt;
    repeat (10 * REF) @(negedge clk);
    chk(ro_cnt - c0 >= 9 && ro_cnt - c0 <= 11, "R7 R8 idle refresh count", ro_cnt - c0, 10);

    // column-before-row refresh
    mode = 1'b1;
    c0 = cbr_cnt;
    c1 = ro_cnt;
    repeat (8 * REF) @(negedge clk);
    chk(cbr_cnt - c0 >= 7 && cbr_cnt - c0 <= 9, "R9 cbr refresh count", cbr_cnt - c0, 8);
    chk(ro_cnt - c1 <= 1, "R9 no pointer refresh in cbr mode", ro_cnt - c1, 0);
    mode = 1'b0;
    for (int k = 0; k < 20; k++) host_op(0, 12'($urandom), 0, 0);

    // long idle so every row is covered
    repeat (66 * REF) @(negedge clk);
    c0 = 0;
    for (int r = 0; r < 64; r++) if (row_ref_cnt[r] == 0) c0++;
    chk(c0 == 0, "R11 rows never refreshed", c0, 0);
    chk(ro_cnt >= 64, "R11 pointer refresh total", ro_cnt, 64);
    host_op(0, 12'hFFF, 0, 0);
    host_op(0, 12'h555, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule